// File: doc/BRIEF.md
# Broadcast Tri-Mode MAC Lane Cluster

A cluster of N identical multiply-accumulate lanes that run in lockstep. Each cycle one signed 8-bit activation is registered and shared by every lane, while each lane takes its own signed 8-bit weight from a packed weight bus. Each lane sorts the shared activation by magnitude into one of three precision classes. In the two low classes it multiplies with a weight whose low bits are cleared (a floor truncation) and adds a +1 correction through the accumulator's carry-in. In the high class it multiplies exactly and adds no correction. The class decision is made inside each lane and never leaves it.

Two magnitude limits select the class. They are written into shadow registers and only move towards the lanes on a commit strobe that arrives while no input is being presented. They then travel down a multi-stage broadcast pipeline, and a busy flag covers the transfer. An accumulation window starts with a first-flagged input and ends with a last-flagged input. After the window ends, every 32-bit lane accumulator is folded into one 32-bit XOR signature by a pipelined reduction tree, and any single lane can be read through a select input.

Top module: `mac_lane_cluster`

## Requirements
- R1: During and straight after reset every lane accumulator reads 0, `sig_o` is 0, `sig_valid_o` and `busy_o` are low, and the committed limits are 3 (low limit) and 12 (high limit).
- R2: A magnitude |a| at or below the low limit selects the coarse class: the term is a times the weight with its low 6 bits cleared (top 2 bits kept, floor in two's complement), plus 1.
- R3: A magnitude above the low limit and at or below the high limit selects the medium class: the term is a times the weight with its low 4 bits cleared, plus 1.
- R4: A magnitude above the high limit selects the exact class: the term is a times w with no correction. The magnitude of -128 is 128.
- R5: An input with `valid_i` and `first_i` high replaces the lane accumulator with its term. An input with only `valid_i` high adds its term (32-bit wrap). Cycles with `valid_i` low leave every accumulator unchanged.
- R6: `sig_valid_o` is high for exactly one cycle, log2(N)+2 rising edges after a last-flagged input is presented, counting the edge that samples it. At that point `sig_o` equals the XOR of all N lane accumulators at the end of the window.
- R7: `lane_acc_o` shows the accumulator of the lane numbered by `lane_sel_i` without a clock delay.
- R8: Limit writes (`thr_we_i`) change only the shadow copy. Lanes keep the committed limits until a commit takes effect.
- R9: A commit is taken only while `valid_i` and `busy_o` are both low. A commit strobe raised together with `valid_i` is dropped: `busy_o` stays low and the old limits stay in force.
- R10: After a taken commit, `busy_o` is high for exactly THR_STAGES cycles (default 3). Inputs presented once `busy_o` is low use the new limits.
- R11: Class boundaries are inclusive and symmetric in sign: |a| equal to a limit belongs to the lower class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input activation and weights present |
| first_i | input | 1 | Input opens a new accumulation window |
| last_i | input | 1 | Input closes the window |
| act_i | input | 8 | Shared signed activation |
| wgt_i | input | LANES*8 | Signed weights, lane k in bits [8k+7:8k] |
| thr_we_i | input | 1 | Write both limits into the shadow copy |
| thr_lo_i | input | 8 | Low magnitude limit (unsigned) |
| thr_hi_i | input | 8 | High magnitude limit (unsigned) |
| commit_i | input | 1 | Request transfer of the shadow limits to the lanes |
| busy_o | output | 1 | Limit transfer in progress |
| lane_sel_i | input | log2(LANES) | Lane chosen for readout |
| lane_acc_o | output | 32 | Accumulator of the chosen lane |
| sig_valid_o | output | 1 | Signature ready, one-cycle pulse |
| sig_o | output | 32 | XOR fold of all lane accumulators |

## Verification
The bench probes activations that sit exactly on each limit and one step past it, in both signs, and includes -128. A lane with an off-by-one comparison or a one-sided magnitude would put the wrong bias or mask into the result. Weights are chosen per lane so that low-bit masking and sign handling differ between lanes; a wrong mask width or a zero-extended product shows up as a wrong lane value or signature. The signature pulse is timed to the exact edge and checked against the XOR of the model's lanes, so a missing tree stage or a pulse that is not aligned with the fold is caught. Limit handling is checked by writing without committing, by committing while an input is present, and by counting busy cycles. Any of these would leave different limits in force for the following window.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_EXACT  = 2'b00,
    MODE_COARSE = 2'b01,
    MODE_MEDIUM = 2'b10
  } mode_e;
endpackage

// File: rtl/thr_bcast.sv
module thr_bcast #(
  parameter int TW         = 8,
  parameter int STAGES     = 3,
  parameter int DEF_LO     = 3,
  parameter int DEF_HI     = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [TW-1:0] lo_i,
  input  logic [TW-1:0] hi_i,
  input  logic          commit_i,
  output logic [TW-1:0] lo_o,
  output logic [TW-1:0] hi_o,
  output logic          busy_o
);
  localparam int CW = $clog2(STAGES + 1);

  logic [TW-1:0] lo_sh, hi_sh;
  logic [TW-1:0] lo_pipe [STAGES];
  logic [TW-1:0] hi_pipe [STAGES];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_sh <= TW'(DEF_LO);
      hi_sh <= TW'(DEF_HI);
    end else if (we_i) begin
      lo_sh <= lo_i;
      hi_sh <= hi_i;
    end
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_pipe[s] <= TW'(DEF_LO);
        hi_pipe[s] <= TW'(DEF_HI);
      end else if (s == 0) begin
        if (commit_i) begin
          lo_pipe[s] <= lo_sh;
          hi_pipe[s] <= hi_sh;
        end
      end else begin
        lo_pipe[s] <= lo_pipe[(s == 0) ? 0 : s-1];
        hi_pipe[s] <= hi_pipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  // busy covers the walk to the last stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (commit_i)     cnt_q <= CW'(STAGES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign lo_o   = lo_pipe[STAGES-1];
  assign hi_o   = hi_pipe[STAGES-1];
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_pkg::*;
#(
  parameter int AW          = 8,
  parameter int WW          = 8,
  parameter int ACC_W       = 32,
  parameter int COARSE_BITS = 2,
  parameter int MEDIUM_BITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 first_i,
  input  logic signed [AW-1:0] act_i,
  input  logic signed [WW-1:0] wgt_i,
  input  logic [AW-1:0]        lo_i,
  input  logic [AW-1:0]        hi_i,
  output logic [ACC_W-1:0]     acc_o
);
  localparam int PW = AW + WW;
  localparam logic [WW-1:0] COARSE_MASK = {{COARSE_BITS{1'b1}}, {(WW-COARSE_BITS){1'b0}}};
  localparam logic [WW-1:0] MEDIUM_MASK = {{MEDIUM_BITS{1'b1}}, {(WW-MEDIUM_BITS){1'b0}}};

  mode_e                 mode;
  logic [AW-1:0]         mag;
  logic signed [WW-1:0]  wsel;
  logic signed [PW-1:0]  prod;
  logic [ACC_W-1:0]      prod_ext, base, acc_q;
  logic                  bias;

  assign mag = act_i[AW-1] ? (~$unsigned(act_i) + AW'(1)) : $unsigned(act_i);

  always_comb begin
    if (mag <= lo_i)      mode = MODE_COARSE;
    else if (mag <= hi_i) mode = MODE_MEDIUM;
    else                  mode = MODE_EXACT;
  end

  always_comb begin
    unique case (mode)
      MODE_COARSE: wsel = $signed(wgt_i & COARSE_MASK);
      MODE_MEDIUM: wsel = $signed(wgt_i & MEDIUM_MASK);
      default:     wsel = wgt_i;
    endcase
  end

  assign prod     = act_i * wsel;
  assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
  assign bias     = (mode != MODE_EXACT);
  assign base     = first_i ? '0 : acc_q;

  // bias enters as carry-in of the accumulate add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= base + prod_ext + {{(ACC_W-1){1'b0}}, bias};
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/xor_tree.sv
module xor_tree #(
  parameter int LEAVES = 64,
  parameter int W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LEAVES*W-1:0] leaf_i,
  output logic [W-1:0]        root_o
);
  localparam int NODES = LEAVES - 1;

  logic [W-1:0] node_q [NODES];
  logic [W-1:0] leaf   [LEAVES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    assign leaf[j] = leaf_i[j*W +: W];
  end

  // heap order: node i has children 2i+1 and 2i+2, leaves follow node NODES-1
  for (genvar i = 0; i < NODES; i++) begin : g_node
    logic [W-1:0] a, b;
    if (2*i+1 >= NODES) begin : g_from_leaf
      assign a = leaf[2*i+1-NODES];
      assign b = leaf[2*i+2-NODES];
    end else begin : g_from_node
      assign a = node_q[2*i+1];
      assign b = node_q[2*i+2];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) node_q[i] <= '0;
      else         node_q[i] <= a ^ b;
    end
  end

  assign root_o = node_q[0];
endmodule

// File: rtl/mac_lane_cluster.sv
module mac_lane_cluster #(
  parameter int LANES      = 64,
  parameter int AW         = 8,
  parameter int WW         = 8,
  parameter int ACC_W      = 32,
  parameter int THR_STAGES = 3,
  parameter int DEF_LO     = 3,
  parameter int DEF_HI     = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     first_i,
  input  logic                     last_i,
  input  logic [AW-1:0]            act_i,
  input  logic [LANES*WW-1:0]      wgt_i,
  input  logic                     thr_we_i,
  input  logic [AW-1:0]            thr_lo_i,
  input  logic [AW-1:0]            thr_hi_i,
  input  logic                     commit_i,
  output logic                     busy_o,
  input  logic [$clog2(LANES)-1:0] lane_sel_i,
  output logic [ACC_W-1:0]         lane_acc_o,
  output logic                     sig_valid_o,
  output logic [ACC_W-1:0]         sig_o
);
  localparam int LVL = $clog2(LANES);

  logic                  valid_q, first_q, last_q;
  logic [AW-1:0]         act_q;
  logic [LANES*WW-1:0]   wgt_q;
  logic [AW-1:0]         lo_b, hi_b;
  logic                  commit_ok;
  logic [ACC_W-1:0]      acc [LANES];
  logic [LANES*ACC_W-1:0] acc_flat;
  logic [LVL:0]          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      act_q   <= '0;
      wgt_q   <= '0;
    end else begin
      valid_q <= valid_i;
      first_q <= valid_i & first_i;
      last_q  <= valid_i & last_i;
      if (valid_i) begin
        act_q <= act_i;
        wgt_q <= wgt_i;
      end
    end
  end

  assign commit_ok = commit_i & ~valid_i & ~busy_o;

  thr_bcast #(
    .TW(AW), .STAGES(THR_STAGES), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
  ) i_thr_bcast (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (thr_we_i),
    .lo_i     (thr_lo_i),
    .hi_i     (thr_hi_i),
    .commit_i (commit_ok),
    .lo_o     (lo_b),
    .hi_o     (hi_b),
    .busy_o   (busy_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    mac_lane #(
      .AW(AW), .WW(WW), .ACC_W(ACC_W)
    ) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_q),
      .first_i (first_q),
      .act_i   ($signed(act_q)),
      .wgt_i   ($signed(wgt_q[k*WW +: WW])),
      .lo_i    (lo_b),
      .hi_i    (hi_b),
      .acc_o   (acc[k])
    );
    assign acc_flat[k*ACC_W +: ACC_W] = acc[k];
  end

  xor_tree #(.LEAVES(LANES), .W(ACC_W)) i_xor_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .leaf_i (acc_flat),
    .root_o (sig_o)
  );

  // window-done marker travels alongside the tree levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= '0;
    else         done_q <= {done_q[LVL-1:0], last_q};
  end

  assign sig_valid_o = done_q[LVL];
  assign lane_acc_o  = acc[lane_sel_i];
endmodule

// File: rtl/mac_lane_cluster_chk.sv
module mac_lane_cluster_chk #(
  parameter int LANES      = 64,
  parameter int THR_STAGES = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic last_i,
  input logic commit_i,
  input logic busy_o,
  input logic sig_valid_o
);
  localparam int LAT = $clog2(LANES) + 2;

  logic [LAT-1:0] end_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) end_sr <= '0;
    else         end_sr <= {end_sr[LAT-2:0], valid_i & last_i};
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !sig_valid_o));

  assert_sig_timing_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o == end_sr[LAT-1]);

  assert_commit_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && valid_i && !busy_o) |=> !busy_o);

  assert_commit_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !valid_i && !busy_o) |=> busy_o);
endmodule

bind mac_lane_cluster mac_lane_cluster_chk #(.LANES(LANES), .THR_STAGES(THR_STAGES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .last_i      (last_i),
  .commit_i    (commit_i),
  .busy_o      (busy_o),
  .sig_valid_o (sig_valid_o)
);

// File: tb/test_mac_lane_cluster.sv
`timescale 1ns/1ps
module test_mac_lane_cluster;
  localparam int LANES = 64;
  localparam int SELW  = $clog2(LANES);
  localparam int LAT   = $clog2(LANES) + 2;
  localparam int STG   = 3;

  // {act, wbase, wstep, first, last}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {8'sd2,    8'sd37,   8'sd3,   1'b1, 1'b0},
    {-8'sd3,   -8'sd100, 8'sd5,   1'b0, 1'b0},
    {8'sd12,   8'sd77,   -8'sd7,  1'b0, 1'b0},
    {-8'sd13,  8'sd5,    8'sd11,  1'b0, 1'b1},
    {8'sd127,  -8'sd128, 8'sd1,   1'b1, 1'b0},
    {-8'sd128, 8'sd127,  -8'sd2,  1'b0, 1'b0},
    {8'sd0,    8'sd64,   8'sd9,   1'b0, 1'b0},
    {8'sd4,    -8'sd1,   8'sd13,  1'b0, 1'b1}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 0, first_i = 0, last_i = 0, thr_we_i = 0, commit_i = 0;
  logic [7:0] act_i = '0, thr_lo_i = '0, thr_hi_i = '0;
  logic [LANES*8-1:0] wgt_i = '0;
  logic [SELW-1:0] lane_sel_i = '0;
  logic busy_o, sig_valid_o;
  logic [31:0] lane_acc_o, sig_o;

  int errors = 0, checks = 0;
  int tlo = 3, thi = 12;
  logic [31:0] macc [LANES];

  always #10 clk_i = ~clk_i;

  mac_lane_cluster #(.LANES(LANES), .THR_STAGES(STG)) i_mac_lane_cluster (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int term(int x, int w);
    int a = (x < 0) ? -x : x;
    if (a <= tlo)      return x * (w & ~63) + 1;
    else if (a <= thi) return x * (w & ~15) + 1;
    else               return x * w;
  endfunction

  task automatic send(input int a, input int wb, input int ws, input bit f, input bit l);
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] wv = 8'(wb + k * ws);
      wgt_i[k*8 +: 8] = wv;
      if (f) macc[k] = 32'(term(a, int'($signed(wv))));
      else   macc[k] = macc[k] + 32'(term(a, int'($signed(wv))));
    end
    act_i = 8'(a); first_i = f; last_i = l; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; first_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic finish_window(input string tag);
    logic [31:0] x = '0;
    for (int k = 0; k < LANES; k++) x ^= macc[k];
    for (int n = 2; n <= LAT; n++) begin
      @(negedge clk_i);
      if (n >= LAT - 1)
        chk(sig_valid_o === (n == LAT), {"R6 pulse ", tag}, 32'(sig_valid_o), 32'(n == LAT));
    end
    chk(sig_o === x, {"R6 signature ", tag}, sig_o, x);
    foreach (macc[k]) begin
      if (k == 0 || k == 1 || k == 29 || k == LANES-1) begin
        lane_sel_i = SELW'(k);
        #1;
        chk(lane_acc_o === macc[k], {"R7 lane readout ", tag}, lane_acc_o, macc[k]);
      end
    end
  endtask

  task automatic write_thr(input int lo, input int hi);
    thr_lo_i = 8'(lo); thr_hi_i = 8'(hi); thr_we_i = 1'b1;
    @(negedge clk_i);
    thr_we_i = 1'b0;
  endtask

  task automatic commit_thr(input int lo, input int hi);
    commit_i = 1'b1;
    @(negedge clk_i);
    commit_i = 1'b0;
    for (int n = 1; n <= STG + 1; n++) begin
      chk(busy_o === (n <= STG), "R10 busy length", 32'(busy_o), 32'(n <= STG));
      if (n <= STG) @(negedge clk_i);
    end
    tlo = lo; thi = hi;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (macc[k]) macc[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(busy_o === 1'b0, "R1 busy in reset", 32'(busy_o), 0);
    chk(sig_valid_o === 1'b0, "R1 sig_valid in reset", 32'(sig_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(sig_o === 32'h0, "R1 signature after reset", sig_o, 0);
    lane_sel_i = SELW'(LANES-1); #1;
    chk(lane_acc_o === 32'h0, "R1 lane after reset", lane_acc_o, 0);

    // table: R2 R3 R4 R5 R11 with default limits
    for (int v = 0; v < NV; v++) begin
      send(int'($signed(VEC[v][25:18])), int'($signed(VEC[v][17:10])),
           int'($signed(VEC[v][9:2])), VEC[v][1], VEC[v][0]);
      if (VEC[v][0]) finish_window($sformatf("R2/R3/R4/R11 table window ending %0d", v));
    end

    // R5 idle cycles inside a window hold the accumulators
    send(13, 50, -3, 1'b1, 1'b0);
    repeat (4) @(negedge clk_i);
    send(-12, -77, 4, 1'b0, 1'b1);
    finish_window("R5 idle gap");

    // R8 shadow write alone changes nothing
    write_thr(0, 0);
    send(2, 100, -5, 1'b1, 1'b1);
    finish_window("R8 write without commit");

    // R9 commit raised together with valid is dropped
    commit_i = 1'b1;
    send(5, -60, 7, 1'b1, 1'b1);
    commit_i = 1'b0;
    chk(busy_o === 1'b0, "R9 busy after dropped commit", 32'(busy_o), 0);
    finish_window("R9 window with dropped commit");
    send(3, 90, -11, 1'b1, 1'b1);
    finish_window("R9 limits unchanged");

    // R10 taken commit: both limits 0
    commit_thr(0, 0);
    send(1, 99, 3, 1'b1, 1'b0);
    send(0, -33, 17, 1'b0, 1'b1);
    finish_window("R10 new limits 0/0");

    // R10 R11 wider limits
    write_thr(20, 100);
    commit_thr(20, 100);
    send(20, 45, 6, 1'b1, 1'b0);
    send(-21, -45, 9, 1'b0, 1'b0);
    send(100, 111, -13, 1'b0, 1'b0);
    send(-101, 17, 5, 1'b0, 1'b1);
    finish_window("R10/R11 limits 20/100");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule